// File: doc/BRIEF.md
# TDM Channel Interrupt Monitor

This block watches the received bytes of a 32-slot time-division serial frame and raises an interrupt when a chosen slot carries a byte of interest. Framing and deserialisation happen upstream: each received byte arrives on a valid/ready input together with its slot number. Two independent monitor paths each select one slot. A path in static mode fires when that slot's byte equals a pattern byte. A path in dynamic mode fires when chosen bits of that slot change from one frame to the next.

When a path fires it sets its flag and stores the byte that caused it in its image register. A byte-wide register port gives software access to configuration and status. Reads of the flag and image registers clear them. A self-clearing bit in the first control register wipes all pending state. The active-low interrupt request stays low while any enabled path is pending. During an acknowledge cycle the read-data bus returns the programmed vector, with its lowest bit naming the source path.

Top module: `tdm_chan_irq_mon`

## Requirements
- R1: After reset `irq_n` is 1 and every register reads 0x00.
- R2: In static mode, when an enabled path sees a byte on its selected slot equal to its pattern byte, the path sets its flag and its image register takes that byte. `irq_n` is low from the cycle after the byte is accepted. Bytes on other slots have no effect.
- R3: In dynamic mode, a bit position takes part only when its mask bit is 1. With toggle off, a pattern bit of 1 detects a 0-to-1 change and a pattern bit of 0 detects a 1-to-0 change, measured against the previous byte of the same slot.
- R4: Bit p of control register 2 (offset 0x01) sets toggle for path p+1. With toggle on, any change on a masked bit fires the path, whatever the pattern bit.
- R5: A dynamic path fires only after it has captured one byte of its slot since reset or since its slot register was last written.
- R6: A path whose enable bit is 0 never sets its flag. `irq_n` is low exactly when some enabled path has its flag set.
- R7: A read of a flag register (0x04/0x05, bit 0 = pending) clears that flag. A read of an image register (0x06/0x07) clears that image. If an event lands in the same cycle, the event wins.
- R8: Writing control register 1 (offset 0x00) with bit 6 set clears both flags and both images in that cycle. Bit 6 always reads 0. In the same write, bits 0/1 enable paths 1/2 and bits 2/3 select dynamic mode for paths 1/2.
- R9: While `iack` is 1, `reg_rdata` shows the vector register (0x02) with bit 0 replaced. That bit is 0 when path 1 is enabled and pending, and 1 otherwise.
- R10: The remaining registers are the mask (0x08/0x09), the pattern (0x0A/0x0B) and the slot (0x0C/0x0D, 5 bits kept, upper bits read 0). Each reads back what was written.
- R11: `in_ready` is always 1. The block never back-pressures, so every beat with `in_valid` set is consumed in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received byte valid |
| in_ready | output | 1 | Always 1 |
| in_chan | input | 5 | Slot number of the received byte |
| in_data | input | 8 | Received byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives clear-on-read) |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, or vector while `iack` is 1 |
| iack | input | 1 | Interrupt acknowledge |
| irq_n | output | 1 | Interrupt request, active low; the pad makes it open drain |

## Verification
The bench builds the block with its default 32 slots and two paths, so every slot number, including slot 31 and the 5-bit truncation of the slot register, is reachable. Random configurations mix static and dynamic paths, with and without toggle, and bias the data towards pattern hits. This produces read-clear, acknowledge and clear-bit operations while flags are both pending and idle.

// File: rtl/tdm_mon_pkg.sv
package tdm_mon_pkg;
  localparam int unsigned NCH   = 32;
  localparam int unsigned CH_W  = $clog2(NCH);
  localparam int unsigned DW    = 8;
  localparam int unsigned NPATH = 2;
  localparam int unsigned AW    = 4;

  localparam logic [AW-1:0] OFS_CTRL1 = 4'h0;
  localparam logic [AW-1:0] OFS_CTRL2 = 4'h1;
  localparam logic [AW-1:0] OFS_VEC   = 4'h2;
  localparam logic [AW-1:0] OFS_FLAG  = 4'h4;
  localparam logic [AW-1:0] OFS_IMG   = 4'h6;
  localparam logic [AW-1:0] OFS_MASK  = 4'h8;
  localparam logic [AW-1:0] OFS_PAT   = 4'hA;
  localparam logic [AW-1:0] OFS_SLOT  = 4'hC;

  localparam int unsigned CLR_BIT = 6;

  typedef struct packed {
    logic            en;
    logic            dyn;
    logic            tog;
    logic [DW-1:0]   mask;
    logic [DW-1:0]   pat;
    logic [CH_W-1:0] slot;
  } path_cfg_t;
endpackage

// File: rtl/tdm_mon_cfg.sv
module tdm_mon_cfg
  import tdm_mon_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr,
  input  logic [AW-1:0]               addr,
  input  logic [DW-1:0]               wdata,
  output path_cfg_t [NPATH-1:0]       cfg,
  output logic [DW-1:0]               vec,
  output logic                        clr_all,
  output logic [NPATH-1:0]            slot_wr,
  output logic [DW-1:0]               ctrl1_rd,
  output logic [DW-1:0]               ctrl2_rd
);
  logic [NPATH-1:0] en_q, dyn_q, tog_q;
  logic [DW-1:0]    vec_q;

  assign clr_all = wr && (addr == OFS_CTRL1) && wdata[CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      dyn_q <= '0;
      tog_q <= '0;
      vec_q <= '0;
    end else if (wr) begin
      if (addr == OFS_CTRL1) begin
        en_q  <= wdata[NPATH-1:0];
        dyn_q <= wdata[2*NPATH-1:NPATH];
      end
      if (addr == OFS_CTRL2) tog_q <= wdata[NPATH-1:0];
      if (addr == OFS_VEC)   vec_q <= wdata;
    end
  end

  for (genvar p = 0; p < NPATH; p++) begin : g_pcfg
    logic [DW-1:0]   mask_q, pat_q;
    logic [CH_W-1:0] slot_q;
    logic            hit_mask, hit_pat, hit_slot;
    assign hit_mask   = wr && (addr == OFS_MASK + AW'(p));
    assign hit_pat    = wr && (addr == OFS_PAT  + AW'(p));
    assign hit_slot   = wr && (addr == OFS_SLOT + AW'(p));
    assign slot_wr[p] = hit_slot;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q <= '0;
        pat_q  <= '0;
        slot_q <= '0;
      end else begin
        if (hit_mask) mask_q <= wdata;
        if (hit_pat)  pat_q  <= wdata;
        if (hit_slot) slot_q <= wdata[CH_W-1:0];
      end
    end

    assign cfg[p].en   = en_q[p];
    assign cfg[p].dyn  = dyn_q[p];
    assign cfg[p].tog  = tog_q[p];
    assign cfg[p].mask = mask_q;
    assign cfg[p].pat  = pat_q;
    assign cfg[p].slot = slot_q;
  end

  assign vec      = vec_q;
  assign ctrl1_rd = DW'({dyn_q, en_q});
  assign ctrl2_rd = DW'(tog_q);
endmodule

// File: rtl/tdm_mon_path.sv
module tdm_mon_path
  import tdm_mon_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  path_cfg_t       cfg,
  input  logic            slot_wr,
  input  logic            in_fire,
  input  logic [CH_W-1:0] in_chan,
  input  logic [DW-1:0]   in_data,
  input  logic            clr_all,
  input  logic            rd_flag,
  input  logic            rd_img,
  output logic            flag,
  output logic [DW-1:0]   image
);
  logic [DW-1:0] prev_q;
  logic          seen_q;
  logic          mine;
  logic [DW-1:0] rise, fall, ev;
  logic          static_hit, dyn_hit, event_now;

  assign mine       = in_fire && (in_chan == cfg.slot);
  assign rise       = ~prev_q & in_data;
  assign fall       = prev_q & ~in_data;
  assign ev         = cfg.mask & (cfg.tog ? (rise | fall)
                                          : ((cfg.pat & rise) | (~cfg.pat & fall)));
  assign static_hit = (in_data == cfg.pat);
  assign dyn_hit    = seen_q && (|ev);
  assign event_now  = mine && cfg.en && (cfg.dyn ? dyn_hit : static_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (slot_wr) begin
      seen_q <= 1'b0;
    end else if (mine) begin
      prev_q <= in_data;
      seen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      image <= '0;
    end else begin
      if (event_now)             flag <= 1'b1;
      else if (clr_all || rd_flag) flag <= 1'b0;
      if (event_now)             image <= in_data;
      else if (clr_all || rd_img)  image <= '0;
    end
  end
endmodule

// File: rtl/tdm_chan_irq_mon.sv
module tdm_chan_irq_mon
  import tdm_mon_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [CH_W-1:0] in_chan,
  input  logic [DW-1:0]   in_data,
  input  logic            reg_wr,
  input  logic            reg_rd,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            iack,
  output logic            irq_n
);
  path_cfg_t [NPATH-1:0] cfg;
  logic [DW-1:0]         vec, ctrl1_rd, ctrl2_rd;
  logic                  clr_all;
  logic [NPATH-1:0]      slot_wr, path_flag, path_en;
  logic [DW-1:0]         path_img [NPATH];
  logic                  in_fire;

  assign in_ready = 1'b1;
  assign in_fire  = in_valid && in_ready;

  tdm_mon_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .cfg(cfg), .vec(vec), .clr_all(clr_all), .slot_wr(slot_wr),
    .ctrl1_rd(ctrl1_rd), .ctrl2_rd(ctrl2_rd)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    logic rd_flag, rd_img;
    assign rd_flag    = reg_rd && !iack && (reg_addr == OFS_FLAG + AW'(p));
    assign rd_img     = reg_rd && !iack && (reg_addr == OFS_IMG  + AW'(p));
    assign path_en[p] = cfg[p].en;
    tdm_mon_path u_path (
      .clk(clk), .rst_n(rst_n), .cfg(cfg[p]), .slot_wr(slot_wr[p]),
      .in_fire(in_fire), .in_chan(in_chan), .in_data(in_data),
      .clr_all(clr_all), .rd_flag(rd_flag), .rd_img(rd_img),
      .flag(path_flag[p]), .image(path_img[p])
    );
  end

  assign irq_n = !(|(path_flag & path_en));

  always_comb begin
    reg_rdata = '0;
    if (iack) begin
      reg_rdata = {vec[DW-1:1], !(path_flag[0] && path_en[0])};
    end else begin
      case (reg_addr)
        OFS_CTRL1: reg_rdata = ctrl1_rd;
        OFS_CTRL2: reg_rdata = ctrl2_rd;
        OFS_VEC:   reg_rdata = vec;
        default: begin
          for (int p = 0; p < NPATH; p++) begin
            if (reg_addr == OFS_FLAG + AW'(p)) reg_rdata = DW'(path_flag[p]);
            if (reg_addr == OFS_IMG  + AW'(p)) reg_rdata = path_img[p];
            if (reg_addr == OFS_MASK + AW'(p)) reg_rdata = cfg[p].mask;
            if (reg_addr == OFS_PAT  + AW'(p)) reg_rdata = cfg[p].pat;
            if (reg_addr == OFS_SLOT + AW'(p)) reg_rdata = DW'(cfg[p].slot);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tdm_chan_irq_mon_chk.sv
module tdm_chan_irq_mon_chk
  import tdm_mon_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [AW-1:0]    reg_addr,
  input logic [DW-1:0]    reg_wdata,
  input logic [DW-1:0]    reg_rdata,
  input logic             iack,
  input logic             irq_n,
  input logic [NPATH-1:0] path_flag,
  input logic [NPATH-1:0] path_en
);
  AST_IDLE_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (path_en == '0) |-> irq_n); // R6
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFS_CTRL1 && reg_wdata[CLR_BIT] && !in_valid) |=> (path_flag == '0)); // R8
  AST_RDCLR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !iack && reg_addr == OFS_FLAG && !in_valid) |=> !path_flag[0]); // R7
  AST_FLAG_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(path_flag[0]) |-> $past(in_valid)); // R2
  AST_VEC_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && path_flag[0] && path_en[0]) |-> (reg_rdata[0] == 1'b0)); // R9
  AST_VEC_SRC2: assert property (@(posedge clk) disable iff (!rst_n)
    (iack && !(path_flag[0] && path_en[0])) |-> reg_rdata[0]); // R9
endmodule

bind tdm_chan_irq_mon tdm_chan_irq_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .iack(iack),
  .irq_n(irq_n), .path_flag(path_flag), .path_en(path_en)
);

// File: tb/tb_tdm_chan_irq_mon.sv
module tb_tdm_chan_irq_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_ready;
  logic [4:0] in_chan = '0;
  logic [7:0] in_data = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0, iack = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic       irq_n;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic       m_en [2], m_dyn [2], m_tog [2], m_seen [2], m_flag [2];
  logic [7:0] m_mask [2], m_pat [2], m_prev [2], m_img [2];
  logic [4:0] m_slot [2];
  logic [7:0] m_vec;

  always #2 clk = ~clk;

  tdm_chan_irq_mon dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_chan(in_chan), .in_data(in_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .iack(iack), .irq_n(irq_n)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic m_irq_n();
    return !((m_flag[0] && m_en[0]) || (m_flag[1] && m_en[1]));
  endfunction

  function automatic logic m_hit(int p, logic [7:0] d);
    logic [7:0] r, f, e;
    if (!m_en[p]) return 1'b0;
    if (!m_dyn[p]) return d == m_pat[p];
    if (!m_seen[p]) return 1'b0;
    r = ~m_prev[p] & d;
    f = m_prev[p] & ~d;
    e = m_mask[p] & (m_tog[p] ? (r | f) : ((m_pat[p] & r) | (~m_pat[p] & f)));
    return |e;
  endfunction

  function automatic logic [7:0] m_read(logic [3:0] a);
    case (a)
      4'h0: return {4'h0, m_dyn[1], m_dyn[0], m_en[1], m_en[0]};
      4'h1: return {6'h0, m_tog[1], m_tog[0]};
      4'h2: return m_vec;
      4'h4: return {7'h0, m_flag[0]};
      4'h5: return {7'h0, m_flag[1]};
      4'h6: return m_img[0];
      4'h7: return m_img[1];
      4'h8: return m_mask[0];
      4'h9: return m_mask[1];
      4'hA: return m_pat[0];
      4'hB: return m_pat[1];
      4'hC: return {3'h0, m_slot[0]};
      4'hD: return {3'h0, m_slot[1]};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_reset();
    for (int p = 0; p < 2; p++) begin
      m_en[p] = 0; m_dyn[p] = 0; m_tog[p] = 0; m_seen[p] = 0; m_flag[p] = 0;
      m_mask[p] = 0; m_pat[p] = 0; m_prev[p] = 0; m_img[p] = 0; m_slot[p] = 0;
    end
    m_vec = 0;
  endtask

  task automatic wreg(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
    case (a)
      4'h0: begin
        m_en[0] = d[0]; m_en[1] = d[1]; m_dyn[0] = d[2]; m_dyn[1] = d[3];
        if (d[6]) for (int p = 0; p < 2; p++) begin m_flag[p] = 0; m_img[p] = 0; end
      end
      4'h1: begin m_tog[0] = d[0]; m_tog[1] = d[1]; end
      4'h2: m_vec = d;
      4'h8, 4'h9: m_mask[a[0]] = d;
      4'hA, 4'hB: m_pat[a[0]] = d;
      4'hC, 4'hD: begin m_slot[a[0]] = d[4:0]; m_seen[a[0]] = 0; end
      default: ;
    endcase
  endtask

  task automatic rchk(string req, logic [3:0] a);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 check(req, reg_rdata, m_read(a));
    @(posedge clk); #1;
    reg_rd = 0;
    if (a == 4'h4 || a == 4'h5) m_flag[a[0]] = 0;
    if (a == 4'h6 || a == 4'h7) m_img[a[0]] = 0;
  endtask

  task automatic send(string req, logic [4:0] ch, logic [7:0] d);
    logic h [2];
    @(negedge clk);
    in_valid = 1; in_chan = ch; in_data = d;
    for (int p = 0; p < 2; p++) h[p] = (ch == m_slot[p]) && m_hit(p, d);
    @(posedge clk); #1;
    in_valid = 0;
    for (int p = 0; p < 2; p++) begin
      if (h[p]) begin m_flag[p] = 1; m_img[p] = d; end
      if (ch == m_slot[p]) begin m_prev[p] = d; m_seen[p] = 1; end
    end
    check(req, {7'h0, irq_n}, {7'h0, m_irq_n()});
  endtask

  task automatic ack_chk();
    @(negedge clk);
    iack = 1;
    #1 check("R9", reg_rdata, {m_vec[7:1], !(m_flag[0] && m_en[0])});
    @(posedge clk); #1;
    iack = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check("R1", {7'h0, irq_n}, 8'h01);
    check("R11", {7'h0, in_ready}, 8'h01);
    foreach (m_en[i]) ;
    for (int a = 0; a < 16; a++) rchk("R1", 4'(a));

    // R10 slot register keeps 5 bits
    wreg(4'hC, 8'hE5);
    rchk("R10", 4'hC);
    wreg(4'h9, 8'h5A); rchk("R10", 4'h9);

    // R2 static match on slot 5
    wreg(4'hA, 8'h3C);
    wreg(4'h2, 8'hA7);
    wreg(4'h0, 8'h01);
    send("R2", 5'd4, 8'h3C);
    send("R2", 5'd5, 8'h11);
    send("R2", 5'd5, 8'h3C);
    check("R2", {7'h0, irq_n}, 8'h00);
    rchk("R2", 4'h6);
    rchk("R7", 4'h6);
    ack_chk();
    rchk("R7", 4'h4);
    check("R7", {7'h0, irq_n}, 8'h01);

    // R3/R5 dynamic on path 2, slot 9
    wreg(4'hD, 8'h09);
    wreg(4'h9, 8'h0F);
    wreg(4'hB, 8'h05);
    wreg(4'h0, 8'h0A);
    send("R5", 5'd9, 8'hFF);
    check("R5", {7'h0, irq_n}, 8'h01);
    send("R3", 5'd9, 8'hF0);
    check("R3", {7'h0, irq_n}, 8'h00);
    rchk("R3", 4'h7);
    rchk("R7", 4'h5);
    send("R3", 5'd9, 8'h00);
    check("R3", {7'h0, irq_n}, 8'h01);
    send("R3", 5'd9, 8'h01);
    check("R3", {7'h0, irq_n}, 8'h00);
    ack_chk();
    wreg(4'h0, 8'h4A);
    check("R8", {7'h0, irq_n}, 8'h01);
    rchk("R8", 4'h0);
    rchk("R8", 4'h7);

    // R4 toggle on path 2
    wreg(4'h1, 8'h02);
    wreg(4'h9, 8'h10);
    wreg(4'hB, 8'h00);
    send("R4", 5'd9, 8'h11);
    check("R4", {7'h0, irq_n}, 8'h00);
    rchk("R4", 4'h5);

    // R6 disabled path
    wreg(4'h0, 8'h08);
    send("R6", 5'd9, 8'h00);
    check("R6", {7'h0, irq_n}, 8'h01);
    rchk("R6", 4'h5);

    // random configurations
    for (int seg = 0; seg < 60; seg++) begin
      wreg(4'h0, 8'($urandom_range(0, 15)) | ((seg % 7 == 3) ? 8'h40 : 8'h00));
      wreg(4'h1, 8'($urandom_range(0, 3)));
      wreg(4'h8, 8'($urandom)); wreg(4'h9, 8'($urandom));
      wreg(4'hA, 8'($urandom)); wreg(4'hB, 8'($urandom));
      if (seg % 3 == 0) begin
        wreg(4'hC, 8'($urandom)); wreg(4'hD, 8'($urandom));
      end
      wreg(4'h2, 8'($urandom));
      for (int b = 0; b < 64; b++) begin
        logic [7:0] d;
        int p;
        p = $urandom_range(0, 1);
        case ($urandom_range(0, 3))
          0: d = m_pat[p];
          1: d = m_prev[p] ^ (8'h01 << $urandom_range(0, 7));
          default: d = 8'($urandom);
        endcase
        send((b % 2) ? "R2" : "R3", 5'(b), d);
        if (b % 16 == 15) rchk("R7", 4'($urandom_range(4, 7)));
        if (b % 32 == 20) ack_chk();
      end
      rchk("R10", 4'($urandom_range(8, 13)));
    end
    check("R11", {7'h0, in_ready}, 8'h01);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule